// File: doc/BRIEF.md
# Timer Tick Source Selector and Prescaler

This block creates the count-enable strobe for a small 16-bit timer counter. It picks one of four tick sources, all handled in the bus clock domain. The sources are the bus clock itself, a one-cycle fixed-frequency strobe, and an external pin. The pin is brought in through a synchronizer and counted on either its falling or its rising edge. Each selected tick advances an 8-bit prescaler. A 4-bit ratio code selects the prescaler tap that fires the count enable, so the division is any power of two from 1 to 256.

Software sets both configuration fields through a single write port. A change to the source or the ratio while the timer runs leaves the prescaler where it is, so counting continues under the new setting. The timer's own restart request clears the prescaler, so the first count after a restart takes a full period. The counter, compare, flags and interrupt live in the neighbouring timer logic. This block only delivers the one-cycle enable pulse.

Top module: `tmr_tick_gen`

## Requirements
- R1: After reset the source field (`src_o`) and the ratio field (`ratio_o`) are both zero and `cnt_en_o` is low.
- R2: Source code 2'b00 takes a tick on every bus clock cycle.
- R3: Source code 2'b01 takes one tick for each bus cycle in which `fix_tick_i` is high.
- R4: Source code 2'b10 takes exactly one tick per falling edge of `ext_pin_i`. With ratio 0, the pulse is seen on `cnt_en_o` after the third rising clock edge that follows the pin change.
- R5: Source code 2'b11 takes exactly one tick per rising edge of `ext_pin_i`, with the same three-edge latency. Edges of the other polarity give no tick.
- R6: Ratio codes 0 to 7 produce one count enable per 2^code source ticks.
- R7: Any ratio code with bit 3 set produces one count enable per 256 source ticks.
- R8: `cnt_en_o` is a registered one-cycle pulse. It appears one clock after the source tick on which the prescaler bits below the selected tap are all ones.
- R9: Writing a new source or ratio does not clear the prescaler, and counting continues from its current value.
- R10: While `cnt_rst_i` is high, the prescaler is cleared and no count enable is issued for that cycle. After a restart, the first enable needs a full 2^code ticks.
- R11: When `wr_en_i` is high, both fields take `wr_src_i` and `wr_ratio_i` at the clock edge. When `wr_en_i` is low, they hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Configuration write strobe |
| wr_src_i | input | 2 | Source code to write |
| wr_ratio_i | input | 4 | Ratio code to write |
| fix_tick_i | input | 1 | Fixed-frequency strobe, high one cycle per tick |
| ext_pin_i | input | 1 | Asynchronous external tick pin |
| cnt_rst_i | input | 1 | Timer restart request, clears the prescaler |
| src_o | output | 2 | Current source field |
| ratio_o | output | 4 | Current ratio field |
| cnt_en_o | output | 1 | One-cycle count-enable pulse |

## Verification
A prescaler that starts in the wrong state, or that is cleared by a configuration write, shows up at the first enable. That pulse comes too early or too late by as many ticks as the error, within one division period. A wrong tap decode changes the number of pulses over a long window, and the sweep over every source and ratio code counts those pulses against the exact quotient. A synchronizer or edge detector that is off by one stage or uses the wrong polarity moves the pin-driven pulse away from the third clock edge, or makes it appear on the wrong edge. Directed pin tests catch this on the first edge.

// File: rtl/tmr_tick_pkg.sv
package tmr_tick_pkg;

    typedef enum logic [1:0] {
        SRC_BUS      = 2'b00,
        SRC_FIX      = 2'b01,
        SRC_PIN_FALL = 2'b10,
        SRC_PIN_RISE = 2'b11
    } tick_src_e;

endpackage

// File: rtl/tmr_pin_edge.sv
// Synchronizes an asynchronous pin into the bus clock domain and flags
// each settled rising or falling transition for exactly one cycle.
module tmr_pin_edge #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic pin_i,
    output logic rise_o,
    output logic fall_o
);

    typedef struct packed {
        logic [STAGES-1:0] chain;
        logic              last;
    } edge_st_t;

    edge_st_t s_d, s_q;
    logic     settled;

    assign settled = s_q.chain[STAGES-1];

    always_comb begin
        s_d       = s_q;
        s_d.chain = {s_q.chain[STAGES-2:0], pin_i};
        s_d.last  = settled;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign rise_o = settled & ~s_q.last;
    assign fall_o = ~settled & s_q.last;

    // R5: a rising transition is flagged for one cycle only
    assert_single_rise_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rise_o |=> !rise_o);

    // R4: a falling transition is flagged for one cycle only
    assert_single_fall_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fall_o |=> !fall_o);

endmodule

// File: rtl/tmr_prescaler.sv
// Power-of-two prescaler: counts source ticks and fires a registered
// enable when the bits below the chosen tap are all ones.
module tmr_prescaler #(
    parameter int unsigned PRESC_W = 8,
    parameter int unsigned RATIO_W = 4
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               tick_i,
    input  logic               clr_i,
    input  logic [RATIO_W-1:0] ratio_i,
    output logic               cnt_en_o
);

    localparam int unsigned TAP_W = $clog2(PRESC_W + 1);
    localparam int unsigned LOW_W = RATIO_W - 1;

    typedef struct packed {
        logic [PRESC_W-1:0] div;
        logic               en;
    } presc_st_t;

    presc_st_t          s_d, s_q;
    logic [TAP_W-1:0]   tap_sel;
    logic [PRESC_W-1:0] tap_mask;

    // Ratio codes with the top bit set saturate at the full prescaler width.
    always_comb begin
        int unsigned low_code;
        low_code = int'(ratio_i[LOW_W-1:0]);
        if (ratio_i[RATIO_W-1] || (low_code > PRESC_W)) begin
            tap_sel = TAP_W'(PRESC_W);
        end else begin
            tap_sel = TAP_W'(low_code);
        end
    end

    for (genvar g = 0; g < PRESC_W; g++) begin : g_mask
        assign tap_mask[g] = (TAP_W'(g) < tap_sel);
    end

    always_comb begin
        s_d    = s_q;
        s_d.en = 1'b0;
        if (clr_i) begin
            s_d.div = '0;
        end else if (tick_i) begin
            s_d.div = s_q.div + 1'b1;
            s_d.en  = ((s_q.div & tap_mask) == tap_mask);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign cnt_en_o = s_q.en;

    // R8: every enable pulse follows a tick taken outside a clear
    assert_pulse_needs_tick_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cnt_en_o |-> $past(tick_i && !clr_i));

    // R10: a clear empties the prescaler and blocks the enable
    assert_clear_empties_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clr_i |=> (s_q.div == '0) && !cnt_en_o);

    // R9: a tick advances the prescaler by one whatever the ratio
    assert_tick_advances_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick_i && !clr_i) |=> s_q.div == $past(s_q.div) + 1'b1);

    // R9: without tick or clear, the prescaler holds even if the ratio changes
    assert_idle_holds_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!tick_i && !clr_i) |=> $stable(s_q.div));

endmodule

// File: rtl/tmr_tick_gen.sv
// Tick source selection, configuration fields and prescaler for a timer.
module tmr_tick_gen
    import tmr_tick_pkg::*;
#(
    parameter int unsigned PRESC_W     = 8,
    parameter int unsigned RATIO_W     = 4,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               wr_en_i,
    input  logic [1:0]         wr_src_i,
    input  logic [RATIO_W-1:0] wr_ratio_i,
    input  logic               fix_tick_i,
    input  logic               ext_pin_i,
    input  logic               cnt_rst_i,
    output logic [1:0]         src_o,
    output logic [RATIO_W-1:0] ratio_o,
    output logic               cnt_en_o
);

    typedef struct packed {
        tick_src_e          src;
        logic [RATIO_W-1:0] ratio;
    } cfg_st_t;

    cfg_st_t cfg_d, cfg_q;
    logic    pin_rise, pin_fall;
    logic    src_tick;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en_i) begin
            cfg_d.src   = tick_src_e'(wr_src_i);
            cfg_d.ratio = wr_ratio_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cfg_q <= '{src: SRC_BUS, ratio: '0};
        end else begin
            cfg_q <= cfg_d;
        end
    end

    tmr_pin_edge #(
        .STAGES (SYNC_STAGES)
    ) u_pin_edge (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .pin_i  (ext_pin_i),
        .rise_o (pin_rise),
        .fall_o (pin_fall)
    );

    always_comb begin
        unique case (cfg_q.src)
            SRC_BUS:      src_tick = 1'b1;
            SRC_FIX:      src_tick = fix_tick_i;
            SRC_PIN_FALL: src_tick = pin_fall;
            SRC_PIN_RISE: src_tick = pin_rise;
            default:      src_tick = 1'b0;
        endcase
    end

    tmr_prescaler #(
        .PRESC_W (PRESC_W),
        .RATIO_W (RATIO_W)
    ) u_presc (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .tick_i   (src_tick),
        .clr_i    (cnt_rst_i),
        .ratio_i  (cfg_q.ratio),
        .cnt_en_o (cnt_en_o)
    );

    assign src_o   = cfg_q.src;
    assign ratio_o = cfg_q.ratio;

    // R11: fields hold while no write is presented
    assert_cfg_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !wr_en_i |=> $stable(src_o) && $stable(ratio_o));

    // R11: a write lands in both fields at the next edge
    assert_cfg_write_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_en_i |=> (src_o == $past(wr_src_i)) && (ratio_o == $past(wr_ratio_i)));

    // R1: the configuration output is never unknown after reset
    assert_cfg_known_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$isunknown({src_o, ratio_o, cnt_en_o}));

endmodule

// File: tb/tmr_tick_gen_tb.sv
`timescale 1ns/1ps
module tmr_tick_gen_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_src = 2'b00;
    logic [3:0] wr_ratio = 4'd0;
    logic       fix_tick = 1'b0;
    logic       ext_pin = 1'b0;
    logic       cnt_rst = 1'b0;
    logic [1:0] src_o;
    logic [3:0] ratio_o;
    logic       cnt_en;

    int n_chk = 0;
    int n_bad = 0;
    int pulses = 0;
    bit done = 1'b0;

    localparam int SWEEP_N = 520;

    always #2.5 clk = ~clk;

    tmr_tick_gen u_dut (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .wr_en_i    (wr_en),
        .wr_src_i   (wr_src),
        .wr_ratio_i (wr_ratio),
        .fix_tick_i (fix_tick),
        .ext_pin_i  (ext_pin),
        .cnt_rst_i  (cnt_rst),
        .src_o      (src_o),
        .ratio_o    (ratio_o),
        .cnt_en_o   (cnt_en)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        pulses += int'(cnt_en);
    endtask

    task automatic cfg_write(input logic [1:0] s, input logic [3:0] r);
        @(negedge clk);
        pulses += int'(cnt_en);
        wr_en = 1'b1; wr_src = s; wr_ratio = r;
        @(negedge clk);
        pulses += int'(cnt_en);
        wr_en = 1'b0;
    endtask

    task automatic restart();
        @(negedge clk);
        cnt_rst = 1'b1;
        @(negedge clk);
        cnt_rst = 1'b0;
        pulses = 0;
    endtask

    task automatic fix_ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            pulses += int'(cnt_en);
            fix_tick = 1'b1;
            @(negedge clk);
            pulses += int'(cnt_en);
            fix_tick = 1'b0;
        end
    endtask

    task automatic pin_periods(input int n);
        for (int i = 0; i < n; i++) begin
            for (int k = 0; k < 4; k++) begin
                @(negedge clk);
                pulses += int'(cnt_en);
                ext_pin = (k < 2);
            end
        end
    endtask

    task automatic drain(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 src", int'(src_o), 0);
        chk("R1 ratio", int'(ratio_o), 0);
        chk("R1 cnt_en", int'(cnt_en), 0);
        @(negedge clk);
        rst_n = 1'b1;
        cnt_rst = 1'b1;

        // R2 R6 R7: bus clock source over every ratio code
        for (int r = 0; r < 16; r++) begin
            int shift;
            shift = (r >= 8) ? 8 : r;
            cfg_write(2'b00, 4'(r));
            restart();
            for (int i = 0; i < SWEEP_N; i++) step();
            cnt_rst = 1'b1;
            chk((r >= 8) ? "R7 bus" : "R2 R6 bus", pulses, SWEEP_N >> shift);
        end
        @(negedge clk);
        cnt_rst = 1'b0;

        // R3 R6 R7: fixed strobe source over every ratio code
        for (int r = 0; r < 16; r++) begin
            int shift;
            shift = (r >= 8) ? 8 : r;
            cfg_write(2'b01, 4'(r));
            restart();
            fix_ticks(SWEEP_N);
            drain(4);
            chk((r >= 8) ? "R7 fix" : "R3 R6 fix", pulses, SWEEP_N >> shift);
        end

        // R4 R5: pin sources, both polarities, every ratio code
        for (int pol = 0; pol < 2; pol++) begin
            for (int r = 0; r < 16; r++) begin
                int shift;
                shift = (r >= 8) ? 8 : r;
                cfg_write(pol ? 2'b11 : 2'b10, 4'(r));
                restart();
                pin_periods(SWEEP_N);
                drain(6);
                chk(pol ? "R5 rise sweep" : "R4 fall sweep", pulses, SWEEP_N >> shift);
            end
        end

        // R5: rising-edge latency and polarity
        cfg_write(2'b11, 4'd0);
        restart();
        drain(6);
        pulses = 0;
        @(negedge clk); ext_pin = 1'b1;
        @(negedge clk); chk("R5 lat edge1", int'(cnt_en), 0);
        @(negedge clk); chk("R5 lat edge2", int'(cnt_en), 0);
        @(negedge clk); chk("R5 lat edge3", int'(cnt_en), 1);
        @(negedge clk); chk("R8 width", int'(cnt_en), 0);
        pulses = 0;
        drain(5);
        ext_pin = 1'b0;
        drain(6);
        chk("R5 falling ignored", pulses, 0);

        // R4: falling-edge latency and polarity
        cfg_write(2'b10, 4'd0);
        pulses = 0;
        @(negedge clk); ext_pin = 1'b1;
        drain(6);
        chk("R4 rising ignored", pulses, 0);
        @(negedge clk); ext_pin = 1'b0;
        @(negedge clk); chk("R4 lat edge1", int'(cnt_en), 0);
        @(negedge clk); chk("R4 lat edge2", int'(cnt_en), 0);
        @(negedge clk); chk("R4 lat edge3", int'(cnt_en), 1);
        @(negedge clk); chk("R8 width fall", int'(cnt_en), 0);

        // R8: one strobe gives one single-cycle pulse one clock later
        cfg_write(2'b01, 4'd0);
        @(negedge clk); fix_tick = 1'b1;
        @(negedge clk); fix_tick = 1'b0;
        chk("R8 pulse after tick", int'(cnt_en), 1);
        @(negedge clk); chk("R8 pulse one cycle", int'(cnt_en), 0);

        // R9: ratio change keeps prescaler (12 ticks, then /8 fires on 4th)
        cfg_write(2'b01, 4'd4);
        restart();
        fix_ticks(12);
        drain(2);
        chk("R9 none before change", pulses, 0);
        cfg_write(2'b01, 4'd3);
        pulses = 0;
        fix_ticks(3);
        drain(2);
        chk("R9 ratio 3 ticks", pulses, 0);
        fix_ticks(1);
        drain(2);
        chk("R9 ratio 4th tick", pulses, 1);

        // R9: source change keeps prescaler (12 strobes, 4 pin rises for /16)
        cfg_write(2'b01, 4'd4);
        restart();
        fix_ticks(12);
        cfg_write(2'b11, 4'd4);
        pulses = 0;
        pin_periods(3);
        drain(6);
        chk("R9 src 3 rises", pulses, 0);
        pin_periods(1);
        drain(6);
        chk("R9 src 4th rise", pulses, 1);

        // R10: restart clears prescaler; first pulse needs a full period
        cfg_write(2'b01, 4'd3);
        restart();
        fix_ticks(5);
        @(negedge clk); cnt_rst = 1'b1; fix_tick = 1'b1;
        @(negedge clk); cnt_rst = 1'b0; fix_tick = 1'b0;
        chk("R10 no pulse on clear", int'(cnt_en), 0);
        pulses = 0;
        fix_ticks(7);
        drain(2);
        chk("R10 7 ticks", pulses, 0);
        fix_ticks(1);
        drain(2);
        chk("R10 8th tick", pulses, 1);

        // R11: write lands; inputs ignored without write strobe
        cfg_write(2'b10, 4'd9);
        chk("R11 src written", int'(src_o), 2);
        chk("R11 ratio written", int'(ratio_o), 9);
        @(negedge clk); wr_src = 2'b01; wr_ratio = 4'd5;
        drain(3);
        chk("R11 src held", int'(src_o), 2);
        chk("R11 ratio held", int'(ratio_o), 9);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule